// File: doc/BRIEF.md
# Configuration Request Header Formatter

This block turns one configuration access request into a three-dword configuration request packet. The request gives a target bus number, a device/function number, a byte address inside the configuration space, an access size of one, two or four bytes, a read/write flag and the write data. From these the block works out the byte enables, moves the write data into the right byte lanes, and picks the first-hop (Type 0) or forwarded (Type 1) form of the request. The packet leaves as 64-bit beats on a transmit stream. The low 32 bits of a beat are its first dword and the high 32 bits are its second dword. Start-of-packet and end-of-packet flags mark the first and last beats.

How many beats a packet takes depends on its content. A write whose register address is quadword aligned gets a beat of its own for the payload, so the packet takes three beats. An unaligned write puts the payload next to the third header dword and takes two beats. A read always takes two beats.

The block keeps a local copy of the root bus number, which it uses for the Type 0/Type 1 choice and as the requester ID. A write to the root port's primary bus number register updates this copy once the completion for that write reports success. The completion status is delivered on two plain pins.

Both edges are valid/ready streams. `req_ready` is high only while no packet is in flight, so a new request waits until the last beat of the previous one is taken. On the transmit side, `tx_ready` low holds the current beat and its flags unchanged for as long as it stays low.

Top module: `cfg_req_fmt`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `busy` rises on the edge that accepts a request and falls on the edge that takes the end-of-packet beat.
- R2: The format/type byte is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write. Type 0 is chosen when `req_bus` equals `root_bus` at acceptance; any other bus gets Type 1.
- R3: Header dword 0 carries the format/type byte in bits [31:24] and the value 1 in its length bits; all its other bits are zero.
- R4: Header dword 1 holds the requester ID {`root_bus`, 8'h00} in bits [31:16], the tag in bits [15:8] and the byte enables in bits [3:0], with bits [7:4] zero. The tag is 0x1D for a read and 0x10 for a write.
- R5: `req_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The byte enables are 4'b0001 shifted left by `req_addr[1:0]` for one byte, and 4'b0011 shifted left by `req_addr[1:0]` and cut to four bits for two bytes. For four bytes they are 4'b1111.
- R6: The payload of a one-byte write is `req_wdata[7:0]` shifted left by 8*`req_addr[1:0]`. For a two-byte write it is `req_wdata[15:0]` shifted the same way and cut to 32 bits. For a four-byte write it is `req_wdata` unshifted. A read's payload slot is zero.
- R7: Header dword 2 holds `req_bus` in bits [31:24] and `req_devfn` in bits [23:16]. Its bits [11:2] hold `req_addr[11:2]`, and all its other bits are zero.
- R8: The first beat of every packet is {dword1, dword0} with only the start flag set. No beat carries both flags.
- R9: A write with `req_addr[2:0]` not zero takes two beats. The second beat is {payload, dword2} with the end flag set.
- R10: A write with `req_addr[2:0]` equal to zero takes three beats. They are {dword1, dword0}, then {0, dword2} with no flag, then {0, payload} with the end flag.
- R11: A read takes two beats whatever its alignment. The second beat is {0, dword2} with the end flag set.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` keep their values into the next cycle.
- R13: `root_bus` changes only on a `cpl_valid` edge that has `cpl_ok` high. The most recently accepted request must be a write to bus `root_bus` with device/function 0 and `req_addr[11:2]` equal to 6 (byte offset 0x18). It then loads the low byte of that write's payload. A failed completion, or any other target, leaves `root_bus` unchanged.
- R14: After reset `tx_valid` and `busy` are low, `req_ready` is high and `root_bus` equals `ROOT_BUS_INIT` (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Downstream takes the beat |
| tx_data | output | 64 | Beat: [31:0] first dword, [63:32] second dword |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| busy | output | 1 | Packet in flight |
| cpl_valid | input | 1 | Completion status of the last request is present |
| cpl_ok | input | 1 | That completion reported success |
| root_bus | output | 8 | Stored root bus number |

## Verification
The bench targets the points where beat count and lane placement change. These are an aligned write next to an unaligned one, an aligned read that must still take two beats, and a two-byte access at byte 3 whose enable is cut to the top lane. A design that tests alignment on address bit 2 only, or that ignores the read/write flag, sends the wrong number of beats. A design that shifts without masking leaks upper write-data bytes into other lanes. The bench stalls the transmit side on a start beat and watches for the beat moving early. It drives root bus updates with a failed completion, with a non-zero device/function and with a forwarded bus. A design that updates on any completion, or that skips the target check, then shows the wrong root bus number, and the next request carries the wrong type and requester ID.

// File: rtl/cfgtlp_pkg.sv
package cfgtlp_pkg;

  // Format/type codes: bit 6 = carries payload, bit 0 = forwarded form.
  localparam logic [7:0] FT_RD_LOCAL = 8'h04;
  localparam logic [7:0] FT_WR_LOCAL = 8'h44;
  localparam logic [7:0] FT_RD_FWD   = 8'h05;
  localparam logic [7:0] FT_WR_FWD   = 8'h45;

  localparam logic [7:0] TAG_RD = 8'h1D;
  localparam logic [7:0] TAG_WR = 8'h10;

  // Access size codes on the request port.
  localparam logic [1:0] SZ_ONE = 2'd0;
  localparam logic [1:0] SZ_TWO = 2'd1;

  typedef struct packed {
    logic [31:0] dw0;
    logic [31:0] dw1;
    logic [31:0] dw2;
    logic [31:0] pay;
    logic        long_form;  // payload gets its own beat
  } pkt_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_MID  = 2'd2,
    ST_LAST = 2'd3
  } beat_st_t;

endpackage

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfgtlp_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PRI_OFFS = 'h18
) (
  input  logic              write,
  input  logic [7:0]        bus,
  input  logic [7:0]        devfn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  input  logic [7:0]        root_bus,
  output pkt_t              pkt,
  output logic              root_hit,
  output logic [7:0]        root_val
);
  localparam int                OFF_W    = 16;
  localparam int                DW_IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] PRI_ADDR = ADDR_W'(PRI_OFFS);

  logic [1:0]  lane;
  logic [4:0]  shamt;
  logic [3:0]  be;
  logic [31:0] lane_data;
  logic [OFF_W-1:0] dw_off;
  logic        local_bus;
  logic [7:0]  fmt;

  assign lane  = addr[1:0];
  assign shamt = {lane, 3'b000};
  assign local_bus = (bus == root_bus);

  always_comb begin
    case (size)
      SZ_ONE: begin
        be        = 4'b0001 << lane;
        lane_data = {24'h0, wdata[7:0]} << shamt;
      end
      SZ_TWO: begin
        be        = 4'b0011 << lane;
        lane_data = {16'h0, wdata[15:0]} << shamt;
      end
      default: begin
        be        = 4'b1111;
        lane_data = wdata;
      end
    endcase
  end

  always_comb begin
    dw_off = '0;
    dw_off[ADDR_W-1:2] = addr[ADDR_W-1:2];
  end

  always_comb begin
    if (write) fmt = local_bus ? FT_WR_LOCAL : FT_WR_FWD;
    else       fmt = local_bus ? FT_RD_LOCAL : FT_RD_FWD;
  end

  always_comb begin
    pkt.dw0       = {fmt, 14'h0, 10'd1};
    pkt.dw1       = {root_bus, 8'h00, (write ? TAG_WR : TAG_RD), 4'h0, be};
    pkt.dw2       = {bus, devfn, dw_off};
    pkt.pay       = write ? lane_data : 32'h0;
    pkt.long_form = write && (addr[2:0] == 3'b000);
  end

  assign root_hit = write && local_bus && (devfn == 8'h00) &&
                    (addr[ADDR_W-1:2] == PRI_ADDR[ADDR_W-1:2]);
  assign root_val = lane_data[7:0];

  // Parameter sanity: offset field of dword 2 is 16 bits wide.
  if (DW_IDX_W < 1 || ADDR_W > OFF_W) begin : g_bad_addr_w
    initial $error("cfg_hdr_build: ADDR_W out of range");
  end

endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfgtlp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  pkt_t        pkt_in,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [63:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        busy
);
  beat_st_t st;
  pkt_t     q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          q  <= pkt_in;
          st <= ST_HEAD;
        end
        ST_HEAD: if (tx_ready) st <= q.long_form ? ST_MID : ST_LAST;
        ST_MID:  if (tx_ready) st <= ST_LAST;
        default: if (tx_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign tx_valid = busy;

  always_comb begin
    tx_sop  = 1'b0;
    tx_eop  = 1'b0;
    tx_data = '0;
    case (st)
      ST_HEAD: begin
        tx_data = {q.dw1, q.dw0};
        tx_sop  = 1'b1;
      end
      ST_MID:  tx_data = {32'h0, q.dw2};
      ST_LAST: begin
        tx_data = q.long_form ? {32'h0, q.pay} : {q.pay, q.dw2};
        tx_eop  = 1'b1;
      end
      default: ;
    endcase
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_sop && tx_eop)); // R8
  AST_START_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> tx_valid && tx_sop); // R8
  AST_IDLE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eop |=> !busy); // R1

endmodule

// File: rtl/cfg_root_track.sv
module cfg_root_track #(
  parameter logic [7:0] ROOT_BUS_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       hit,
  input  logic [7:0] val,
  input  logic       cpl_valid,
  input  logic       cpl_ok,
  output logic [7:0] root_bus
);
  logic       pend_hit;
  logic [7:0] pend_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_bus <= ROOT_BUS_INIT;
      pend_hit <= 1'b0;
      pend_val <= '0;
    end else begin
      if (cpl_valid) begin
        if (pend_hit && cpl_ok) root_bus <= pend_val;
        pend_hit <= 1'b0;
      end
      if (capture) begin
        pend_hit <= hit;
        pend_val <= val;
      end
    end
  end

  AST_ROOT_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpl_valid && cpl_ok) |=> $stable(root_bus)); // R13

endmodule

// File: rtl/cfg_req_fmt.sv
module cfg_req_fmt
  import cfgtlp_pkg::*;
#(
  parameter int         ADDR_W        = 12,
  parameter int         PRI_OFFS      = 'h18,
  parameter logic [7:0] ROOT_BUS_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [63:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              busy,
  input  logic              cpl_valid,
  input  logic              cpl_ok,
  output logic [7:0]        root_bus
);
  pkt_t       pkt;
  logic       hit;
  logic [7:0] hit_val;
  logic       accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  cfg_hdr_build #(.ADDR_W(ADDR_W), .PRI_OFFS(PRI_OFFS)) u_build (
    .write    (req_write),
    .bus      (req_bus),
    .devfn    (req_devfn),
    .addr     (req_addr),
    .size     (req_size),
    .wdata    (req_wdata),
    .root_bus (root_bus),
    .pkt      (pkt),
    .root_hit (hit),
    .root_val (hit_val)
  );

  cfg_beat_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .pkt_in   (pkt),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .busy     (busy)
  );

  cfg_root_track #(.ROOT_BUS_INIT(ROOT_BUS_INIT)) u_root (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .hit       (hit),
    .val       (hit_val),
    .cpl_valid (cpl_valid),
    .cpl_ok    (cpl_ok),
    .root_bus  (root_bus)
  );

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R1
  AST_FIRST_BEAT_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data[23:0] == 24'h1 && tx_data[39:36] == 4'h0); // R3

endmodule

// File: tb/test_cfg_req_fmt.sv
`timescale 1ns/1ps
module test_cfg_req_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [63:0] tx_data;
  logic        tx_sop;
  logic        tx_eop;
  logic        busy;
  logic        cpl_valid = 1'b0;
  logic        cpl_ok = 1'b0;
  logic [7:0]  root_bus;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_req_fmt i_cfg_req_fmt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .busy(busy),
    .cpl_valid(cpl_valid), .cpl_ok(cpl_ok), .root_bus(root_bus)
  );

  // {write, bus, devfn, addr, size, wdata, beats, byte enables}
  localparam int NV = 9;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0000_0000, 2'd2, 4'b1111},
    {1'b0, 8'h01, 8'h08, 12'h10E, 2'd1, 32'h0000_0000, 2'd2, 4'b1100},
    {1'b1, 8'h00, 8'h00, 12'h005, 2'd0, 32'hFFFF_FFAB, 2'd2, 4'b0010},
    {1'b1, 8'h02, 8'h11, 12'h03A, 2'd1, 32'h1234_BEEF, 2'd2, 4'b1100},
    {1'b1, 8'h00, 8'h00, 12'h040, 2'd2, 32'hDEAD_BEEF, 2'd3, 4'b1111},
    {1'b1, 8'h03, 8'h21, 12'h0F3, 2'd1, 32'h0000_CAFE, 2'd2, 4'b1000},
    {1'b1, 8'h04, 8'h00, 12'h108, 2'd0, 32'h7777_775A, 2'd3, 4'b0001},
    {1'b1, 8'h00, 8'h00, 12'h0FC, 2'd3, 32'h0102_0304, 2'd2, 4'b1111},
    {1'b1, 8'h00, 8'h05, 12'h006, 2'd2, 32'h1122_3344, 2'd2, 4'b1111}
  };

  logic [63:0] exp_b [3];
  int          exp_n;
  logic [63:0] got_b [4];
  logic        got_s [4];
  logic        got_e [4];
  int          got_n;
  logic [7:0]  exp_root = 8'h00;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected packet, built from the requirement text.
  task automatic model(input logic w, input logic [7:0] bus, input logic [7:0] dfn,
                       input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd,
                       input logic [7:0] root);
    logic [3:0]  be;
    logic [31:0] pay, d0, d1, d2;
    logic [7:0]  ft;
    int          sh;
    sh = 8 * int'(a[1:0]);
    if (sz == 2'd0) begin be = 4'(4'd1 << a[1:0]); pay = (wd & 32'hFF) << sh; end
    else if (sz == 2'd1) begin be = 4'(4'd3 << a[1:0]); pay = (wd & 32'hFFFF) << sh; end
    else begin be = 4'hF; pay = wd; end
    if (!w) pay = 32'h0;
    if (bus == root) ft = w ? 8'h44 : 8'h04;
    else             ft = w ? 8'h45 : 8'h05;
    d0 = {ft, 24'h000001};
    d1 = {root, 8'h00, (w ? 8'h10 : 8'h1D), 4'h0, be};
    d2 = {bus, dfn, 4'h0, a[11:2], 2'b00};
    exp_b[0] = {d1, d0};
    if (w && a[2:0] == 3'b000) begin
      exp_n = 3;
      exp_b[1] = {32'h0, d2};
      exp_b[2] = {32'h0, pay};
    end else begin
      exp_n = 2;
      exp_b[1] = {pay, d2};
      exp_b[2] = '0;
    end
  endtask

  task automatic issue(input logic w, input logic [7:0] bus, input logic [7:0] dfn,
                       input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    req_write = w; req_bus = bus; req_devfn = dfn; req_addr = a;
    req_size = sz; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic gather();
    got_n = 0;
    for (int i = 0; i < 12; i++) begin
      if (tx_valid && tx_ready && got_n < 4) begin
        got_b[got_n] = tx_data; got_s[got_n] = tx_sop; got_e[got_n] = tx_eop;
        got_n++;
        if (tx_eop) break;
      end
      @(negedge clk);
    end
  endtask

  task automatic compare(input string tag);
    chk(got_n == exp_n, {tag, " beat count R9 R10 R11"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_b[i] == exp_b[i], {tag, " beat data R2 R3 R4 R6 R7"}, got_b[i], exp_b[i]);
      chk(got_s[i] == (i == 0) && got_e[i] == (i == exp_n - 1),
          {tag, " flags R8"}, {62'h0, got_s[i], got_e[i]},
          {62'h0, 1'(i == 0), 1'(i == exp_n - 1)});
    end
  endtask

  task automatic cpl_pulse(input logic ok);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_ok = ok;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_ok = 1'b0;
  endtask

  task automatic run_one(input string tag, input logic w, input logic [7:0] bus,
                         input logic [7:0] dfn, input logic [11:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
    model(w, bus, dfn, a, sz, wd, exp_root);
    issue(w, bus, dfn, a, sz, wd);
    gather();
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(!tx_valid && !busy && req_ready, "R14 reset handshake", {61'h0, tx_valid, busy, req_ready}, 64'h1);
    chk(root_bus == 8'h00, "R14 reset root bus", 64'(root_bus), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !busy && req_ready, "R14 after reset release", {61'h0, tx_valid, busy, req_ready}, 64'h1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [68:0] e;
      e = VEC[v];
      model(e[68], e[67:60], e[59:52], e[51:40], e[39:38], e[37:6], exp_root);
      issue(e[68], e[67:60], e[59:52], e[51:40], e[39:38], e[37:6]);
      gather();
      compare($sformatf("vec%0d", v));
      chk(got_n == int'(e[5:4]), "R9 R10 R11 table beat count", 64'(got_n), 64'(e[5:4]));
      chk(got_b[0][35:32] == e[3:0], "R5 byte enables", 64'(got_b[0][35:32]), 64'(e[3:0]));
    end

    // R1 busy through a three-beat packet, request held off
    model(1'b1, 8'h00, 8'h00, 12'h020, 2'd2, 32'hA5A5_5A5A, exp_root);
    issue(1'b1, 8'h00, 8'h00, 12'h020, 2'd2, 32'hA5A5_5A5A);
    chk(busy && !req_ready, "R1 busy on first beat", {62'h0, busy, req_ready}, 64'h2);
    req_valid = 1'b1; req_write = 1'b0; req_bus = 8'h09;
    gather();
    req_valid = 1'b0;
    compare("R1 held-off");
    @(negedge clk);
    chk(!busy && req_ready && !tx_valid, "R1 idle after eop", {61'h0, busy, req_ready, tx_valid}, 64'h2);

    // R12 back-pressure on the start beat
    model(1'b1, 8'h06, 8'h10, 12'h0A8, 2'd0, 32'h0000_00C3, exp_root);
    tx_ready = 1'b0;
    issue(1'b1, 8'h06, 8'h10, 12'h0A8, 2'd0, 32'h0000_00C3);
    for (int k = 0; k < 3; k++) begin
      chk(tx_valid && tx_sop && !tx_eop && tx_data == exp_b[0], "R12 stalled beat held", tx_data, exp_b[0]);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    gather();
    compare("R12 after stall");

    // R13 root bus tracking
    run_one("R13 wr fail", 1'b1, 8'h00, 8'h00, 12'h018, 2'd0, 32'h0000_0005);
    cpl_pulse(1'b0);
    chk(root_bus == 8'h00, "R13 failed completion ignored", 64'(root_bus), 64'h0);
    run_one("R13 wr ok", 1'b1, 8'h00, 8'h00, 12'h018, 2'd0, 32'h0000_0005);
    cpl_pulse(1'b1);
    exp_root = 8'h05;
    chk(root_bus == 8'h05, "R13 root bus loaded", 64'(root_bus), 64'h5);
    run_one("R13 R2 new root read", 1'b0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0);
    run_one("R2 old root now fwd", 1'b0, 8'h00, 8'h00, 12'h004, 2'd2, 32'h0);
    run_one("R13 devfn nonzero", 1'b1, 8'h05, 8'h08, 12'h018, 2'd0, 32'h0000_0033);
    cpl_pulse(1'b1);
    chk(root_bus == 8'h05, "R13 devfn nonzero ignored", 64'(root_bus), 64'h5);
    run_one("R13 fwd bus", 1'b1, 8'h07, 8'h00, 12'h018, 2'd0, 32'h0000_0044);
    cpl_pulse(1'b1);
    chk(root_bus == 8'h05, "R13 forwarded bus ignored", 64'(root_bus), 64'h5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule